// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-up to the point where normal traffic may begin. Until supply stability is reported, it holds the clock enable low. It then waits for the clock to settle, for a cycle count derived from the clock frequency and a time in microseconds. After that it raises the clock enable with a no-operation cycle and issues the mandatory command series. That series enables the DLL through the extended mode register and resets the DLL through the mode register. It then precharges all banks, runs a parameterized number of auto-refresh cycles and writes the final mode register with the DLL-reset bit cleared.

Every gap between commands is counted in clock cycles from module parameters: the mode-register gap, the precharge gap, the refresh gap and the DLL lock time. The DLL lock window runs alongside the precharge and refresh steps, and it holds back only the final mode-register write. When the last gap has passed, the block raises `init_done`. From then on it passes the rest of the controller's clock enable and command bus straight through to the memory, until reset is applied again.

Top module: `ddr_powerup_seq`

## Requirements
- R1: From reset, `cke` is low. It stays low while `pwr_stable` is low and for STABLE_CYC = CLK_MHZ*STABLE_US cycles after the cycle in which `pwr_stable` is first sampled high. In the next cycle `cke` goes high with a no-operation on the bus, and the first command may come one cycle later.
- R2: The command bus {cs_n, ras_n, cas_n, we_n} uses these codes: no-operation 0111, precharge 0010, auto-refresh 0001, mode-register write 0000. Before `init_done`, every cycle that is not a command cycle carries no-operation.
- R3: The commands come in this order: precharge, extended mode write (ba=01), mode write with A8=1 (ba=00), precharge, N_REF auto-refreshes (ba=00, address 0), mode write with A8=0 (ba=00).
- R4: Each precharge drives A10=1 with ba=00 and all other address bits 0, so it closes all banks.
- R5: The mode write carries A[2:0]=BL_CODE, A3=0, A[6:4]=CL_CODE and A8 as the DLL-reset bit, with other bits 0. The extended mode write carries A0=0 (DLL on) and A1=DRV_REDUCED, with other bits 0.
- R6: The next command follows a mode or extended mode write exactly T_MRD cycles later (T_MRD is at least 2).
- R7: The next command follows a precharge exactly T_RP cycles later.
- R8: The next command follows an auto-refresh exactly T_RFC cycles later.
- R9: The final mode write is issued in the later of two cycles: the last refresh plus T_RFC, or the DLL-reset write plus DLL_LOCK.
- R10: `init_done` rises T_MRD+1 cycles after the final mode write. It then stays high until reset, whatever `pwr_stable` does.
- R11: While `init_done` is high, `cke`, the command pins, `ba` and `addr` equal the matching `ctl_*` inputs in the same cycle.
- R12: Reset applied mid-sequence at once drives `cke` low, no-operation and `init_done` low. After release the whole sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies are stable |
| ctl_cke | input | 1 | Controller clock enable, used after init |
| ctl_cs_n | input | 1 | Controller chip select, used after init |
| ctl_ras_n | input | 1 | Controller row strobe, used after init |
| ctl_cas_n | input | 1 | Controller column strobe, used after init |
| ctl_we_n | input | 1 | Controller write enable, used after init |
| ctl_ba | input | 2 | Controller bank address, used after init |
| ctl_addr | input | ADDR_W | Controller address, used after init |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Memory chip select |
| ras_n | output | 1 | Memory row strobe |
| cas_n | output | 1 | Memory column strobe |
| we_n | output | 1 | Memory write enable |
| ba | output | 2 | Memory bank address |
| addr | output | ADDR_W | Memory address |
| init_done | output | 1 | Initialization complete |

## Verification
The outputs are decoded without a register from the sequencer state and its gap counter. A command therefore appears in exactly the cycle its gap expires. The stable-clock wait ends STABLE_CYC+1 cycles after `pwr_stable` is taken, and `init_done` follows T_MRD+1 cycles after the final mode write. The bench records the cycle index of the `pwr_stable` hand-off and the cycle index of every command, sampling on the falling edge. It compares each one with an offset it computes from the timing parameters, so a command issued one cycle early or one cycle late is flagged. The pass-through after completion has no delay and is checked within the same cycle in which its inputs change.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // Command codes on {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS  = 4'b0000,
      CMD_AREF = 4'b0001,
      CMD_PRE  = 4'b0010,
      CMD_NOP  = 4'b0111
   } ddr_cmd_e;

   typedef enum logic [3:0] {
      ST_PWR,
      ST_STAB,
      ST_NOP,
      ST_PRE1,
      ST_EMRS,
      ST_MRS_RST,
      ST_PRE2,
      ST_REF,
      ST_MRS_RUN,
      ST_FIN,
      ST_DONE
   } init_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/init_interval_cnt.sv
module init_interval_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= load_val;
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign expired = (remain == '0);

   // An armed count never jumps straight to zero
   AST_CNT_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remain > CNT_W'(1)) |=> !expired); // R6

endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word #(
   parameter int unsigned ADDR_W      = 13,
   parameter logic [2:0]  BL_CODE     = 3'b011,
   parameter logic [2:0]  CL_CODE     = 3'b010,
   parameter bit          DRV_REDUCED = 1'b0
) (
   input  logic              dll_reset,
   output logic [ADDR_W-1:0] mrs_word,
   output logic [ADDR_W-1:0] emrs_word
);

   always_comb begin
      mrs_word      = '0;
      mrs_word[2:0] = BL_CODE;
      mrs_word[3]   = 1'b0;       // sequential bursts
      mrs_word[6:4] = CL_CODE;
      mrs_word[8]   = dll_reset;
      emrs_word     = '0;
      emrs_word[0]  = 1'b0;       // DLL enabled
      emrs_word[1]  = DRV_REDUCED;
   end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
   import ddr_init_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned CLK_MHZ     = 50,
   parameter int unsigned STABLE_US   = 200,
   parameter int unsigned T_RP        = 3,
   parameter int unsigned T_RFC       = 10,
   parameter int unsigned T_MRD       = 2,
   parameter int unsigned DLL_LOCK    = 200,
   parameter int unsigned N_REF       = 2,
   parameter logic [2:0]  BL_CODE     = 3'b011,
   parameter logic [2:0]  CL_CODE     = 3'b010,
   parameter bit          DRV_REDUCED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_stable,
   input  logic              ctl_cke,
   input  logic              ctl_cs_n,
   input  logic              ctl_ras_n,
   input  logic              ctl_cas_n,
   input  logic              ctl_we_n,
   input  logic [1:0]        ctl_ba,
   input  logic [ADDR_W-1:0] ctl_addr,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
   localparam int unsigned MAX_GAP    = max2(max2(STABLE_CYC, T_RP), max2(T_RFC, T_MRD));
   localparam int unsigned CNT_W      = $clog2(MAX_GAP + 1);
   localparam int unsigned REF_W      = $clog2(N_REF);
   localparam int unsigned DLL_W      = (DLL_LOCK > 1) ? $clog2(DLL_LOCK + 1) : 1;
   localparam int unsigned CHK_W      = $clog2(max2(MAX_GAP, DLL_LOCK) + 2) + 1;

   // Elaboration-time parameter checks
   if (ADDR_W < 11)      begin : g_bad_addr   $error("ADDR_W must reach A10");         end
   if (T_MRD < 2)        begin : g_bad_mrd    $error("T_MRD must be at least 2");      end
   if (N_REF < 2)        begin : g_bad_ref    $error("N_REF must be at least 2");      end
   if (T_RP < 1)         begin : g_bad_rp     $error("T_RP must be at least 1");       end
   if (T_RFC < 1)        begin : g_bad_rfc    $error("T_RFC must be at least 1");      end
   if (STABLE_CYC < 1)   begin : g_bad_stab   $error("stable wait must be non-zero"); end

   init_state_e       state, state_nxt;
   logic [REF_W-1:0]  ref_cnt;
   logic              ref_step;
   logic              gap_load, gap_zero;
   logic [CNT_W-1:0]  gap_val;
   logic              dll_load, dll_ready;
   ddr_cmd_e          fsm_cmd;
   logic              fsm_cke;
   logic [1:0]        fsm_ba;
   logic [ADDR_W-1:0] fsm_addr;
   logic [ADDR_W-1:0] mrs_word, emrs_word;
   logic              mrs_dll_rst;

   init_interval_cnt #(.CNT_W(CNT_W)) i_gap_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .expired  (gap_zero)
   );

   // DLL lock window runs beside the precharge and refresh steps
   if (DLL_LOCK > 0) begin : g_dll_wait
      init_interval_cnt #(.CNT_W(DLL_W)) i_dll_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (dll_load),
         .load_val (DLL_W'(DLL_LOCK - 1)),
         .expired  (dll_ready)
      );
   end else begin : g_dll_none
      assign dll_ready = 1'b1;
   end

   ddr_mode_word #(
      .ADDR_W      (ADDR_W),
      .BL_CODE     (BL_CODE),
      .CL_CODE     (CL_CODE),
      .DRV_REDUCED (DRV_REDUCED)
   ) i_mode_word (
      .dll_reset (mrs_dll_rst),
      .mrs_word  (mrs_word),
      .emrs_word (emrs_word)
   );

   assign mrs_dll_rst = (state == ST_MRS_RST);

   always_comb begin
      state_nxt = state;
      fsm_cmd   = CMD_NOP;
      fsm_cke   = 1'b1;
      fsm_ba    = 2'b00;
      fsm_addr  = '0;
      gap_load  = 1'b0;
      gap_val   = '0;
      dll_load  = 1'b0;
      ref_step  = 1'b0;
      case (state)
         ST_PWR: begin
            fsm_cke = 1'b0;
            if (pwr_stable) begin
               gap_load  = 1'b1;
               gap_val   = CNT_W'(STABLE_CYC - 1);
               state_nxt = ST_STAB;
            end
         end
         ST_STAB: begin
            fsm_cke = 1'b0;
            if (gap_zero) state_nxt = ST_NOP;
         end
         ST_NOP: state_nxt = ST_PRE1;
         ST_PRE1, ST_PRE2: begin
            if (gap_zero) begin
               fsm_cmd      = CMD_PRE;
               fsm_addr[10] = 1'b1;
               gap_load     = 1'b1;
               gap_val      = CNT_W'(T_RP - 1);
               state_nxt    = (state == ST_PRE1) ? ST_EMRS : ST_REF;
            end
         end
         ST_EMRS: begin
            if (gap_zero) begin
               fsm_cmd   = CMD_MRS;
               fsm_ba    = 2'b01;
               fsm_addr  = emrs_word;
               gap_load  = 1'b1;
               gap_val   = CNT_W'(T_MRD - 1);
               state_nxt = ST_MRS_RST;
            end
         end
         ST_MRS_RST: begin
            if (gap_zero) begin
               fsm_cmd   = CMD_MRS;
               fsm_addr  = mrs_word;
               gap_load  = 1'b1;
               gap_val   = CNT_W'(T_MRD - 1);
               dll_load  = 1'b1;
               state_nxt = ST_PRE2;
            end
         end
         ST_REF: begin
            if (gap_zero) begin
               fsm_cmd  = CMD_AREF;
               gap_load = 1'b1;
               gap_val  = CNT_W'(T_RFC - 1);
               ref_step = 1'b1;
               if (ref_cnt == REF_W'(N_REF - 1)) state_nxt = ST_MRS_RUN;
            end
         end
         ST_MRS_RUN: begin
            if (gap_zero && dll_ready) begin
               fsm_cmd   = CMD_MRS;
               fsm_addr  = mrs_word;
               gap_load  = 1'b1;
               gap_val   = CNT_W'(T_MRD - 1);
               state_nxt = ST_FIN;
            end
         end
         ST_FIN:  if (gap_zero) state_nxt = ST_DONE;
         default: state_nxt = ST_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_PWR;
         ref_cnt <= '0;
      end else begin
         state <= state_nxt;
         if (ref_step) ref_cnt <= ref_cnt + 1'b1;
      end
   end

   assign init_done = (state == ST_DONE);

   always_comb begin
      if (init_done) begin
         cke                      = ctl_cke;
         {cs_n, ras_n, cas_n, we_n} = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n};
         ba                       = ctl_ba;
         addr                     = ctl_addr;
      end else begin
         cke                      = fsm_cke;
         {cs_n, ras_n, cas_n, we_n} = fsm_cmd;
         ba                       = fsm_ba;
         addr                     = fsm_addr;
      end
   end

   // ---------------- port-level checks ----------------
   logic [3:0]       bus_cmd;
   logic             bus_issue;
   logic [3:0]       last_kind;
   logic [CHK_W-1:0] since_cmd, since_dll;
   logic             dll_seen;

   assign bus_cmd   = {cs_n, ras_n, cas_n, we_n};
   assign bus_issue = !init_done && (bus_cmd != CMD_NOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_kind <= CMD_NOP;
         since_cmd <= '0;
         since_dll <= '0;
         dll_seen  <= 1'b0;
      end else begin
         if (bus_issue) begin
            last_kind <= bus_cmd;
            since_cmd <= CHK_W'(1);
         end else if (since_cmd != '1) begin
            since_cmd <= since_cmd + 1'b1;
         end
         if (bus_issue && bus_cmd == CMD_MRS && ba == 2'b00 && addr[8]) begin
            dll_seen  <= 1'b1;
            since_dll <= CHK_W'(1);
         end else if (since_dll != '1) begin
            since_dll <= since_dll + 1'b1;
         end
      end
   end

   AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_issue |-> cke); // R1
   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> (bus_cmd inside {CMD_NOP, CMD_PRE, CMD_AREF, CMD_MRS})); // R2
   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_issue && bus_cmd == CMD_PRE) |-> addr[10]); // R4
   AST_GAP_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_issue && last_kind == CMD_MRS) |-> since_cmd >= CHK_W'(T_MRD)); // R6
   AST_GAP_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_issue && last_kind == CMD_PRE) |-> since_cmd >= CHK_W'(T_RP)); // R7
   AST_GAP_AFTER_AREF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_issue && last_kind == CMD_AREF) |-> since_cmd >= CHK_W'(T_RFC)); // R8
   AST_DLL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_issue && bus_cmd == CMD_MRS && ba == 2'b00 && !addr[8])
         |-> (dll_seen && since_dll >= CHK_W'(DLL_LOCK))); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done); // R10

endmodule

// File: tb/test_ddr_powerup_seq.sv
`timescale 1ns/1ps
module test_ddr_powerup_seq;

   localparam int ADDR_W    = 13;
   localparam int CLK_MHZ   = 50;
   localparam int STABLE_US = 2;
   localparam int T_RP      = 3;
   localparam int T_RFC     = 9;
   localparam int T_MRD     = 2;
   localparam int DLL_LOCK  = 40;
   localparam int N_REF     = 3;
   localparam logic [2:0] BL = 3'b010;
   localparam logic [2:0] CL = 3'b011;
   localparam bit DRV       = 1'b1;
   localparam int WD_LIMIT  = 5000;

   // Expected offsets from the pwr_stable hand-off cycle (R1, R6-R10)
   localparam int S      = CLK_MHZ * STABLE_US;
   localparam int O_CKE  = S + 1;
   localparam int O_P1   = S + 2;
   localparam int O_E    = O_P1 + T_RP;
   localparam int O_MR   = O_E + T_MRD;
   localparam int O_P2   = O_MR + T_MRD;
   localparam int O_R1   = O_P2 + T_RP;
   localparam int O_R2   = O_R1 + T_RFC;
   localparam int O_R3   = O_R2 + T_RFC;
   localparam int O_MF   = (O_R3 + T_RFC > O_MR + DLL_LOCK) ? O_R3 + T_RFC : O_MR + DLL_LOCK;
   localparam int O_DONE = O_MF + T_MRD + 1;

   localparam logic [12:0] A_PRE  = 13'h400;
   localparam logic [12:0] A_EMRS = {11'd0, DRV, 1'b0};
   localparam logic [12:0] A_MRS1 = {4'd0, 1'b1, 1'b0, CL, 1'b0, BL};
   localparam logic [12:0] A_MRS0 = {4'd0, 1'b0, 1'b0, CL, 1'b0, BL};

   // {offset[15:0], cmd[3:0], ba[1:0], addr[12:0]}
   localparam logic [34:0] EXP_SEQ [8] = '{
      {16'(O_P1), 4'b0010, 2'b00, A_PRE},
      {16'(O_E),  4'b0000, 2'b01, A_EMRS},
      {16'(O_MR), 4'b0000, 2'b00, A_MRS1},
      {16'(O_P2), 4'b0010, 2'b00, A_PRE},
      {16'(O_R1), 4'b0001, 2'b00, 13'h000},
      {16'(O_R2), 4'b0001, 2'b00, 13'h000},
      {16'(O_R3), 4'b0001, 2'b00, 13'h000},
      {16'(O_MF), 4'b0000, 2'b00, A_MRS0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_stable = 1'b0;
   logic ctl_cke = 1'b0, ctl_cs_n = 1'b1, ctl_ras_n = 1'b1, ctl_cas_n = 1'b1, ctl_we_n = 1'b1;
   logic [1:0] ctl_ba = 2'b00;
   logic [ADDR_W-1:0] ctl_addr = '0;
   logic cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [1:0] ba;
   logic [ADDR_W-1:0] addr;

   ddr_powerup_seq #(
      .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US),
      .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK),
      .N_REF(N_REF), .BL_CODE(BL), .CL_CODE(CL), .DRV_REDUCED(DRV)
   ) i_ddr_powerup_seq (
      .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
      .ctl_cke(ctl_cke), .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n),
      .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_ba(ctl_ba), .ctl_addr(ctl_addr),
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .init_done(init_done)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT && !finished) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // Command recorder
   bit rec_clr = 1'b0;
   int n_rec = 0;
   int bad_codes = 0;
   int rec_cyc [16];
   logic [3:0] rec_cmd [16];
   logic [1:0] rec_ba [16];
   logic [12:0] rec_addr [16];

   always @(negedge clk) begin
      if (rec_clr) begin
         n_rec = 0;
         bad_codes = 0;
      end else if (rst_n && !init_done) begin
         if (!({cs_n, ras_n, cas_n, we_n} inside {4'b0111, 4'b0010, 4'b0001, 4'b0000}))
            bad_codes = bad_codes + 1;
         if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
            if (n_rec < 16) begin
               rec_cyc[n_rec]  = cyc;
               rec_cmd[n_rec]  = {cs_n, ras_n, cas_n, we_n};
               rec_ba[n_rec]   = ba;
               rec_addr[n_rec] = addr;
            end
            n_rec = n_rec + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests = n_tests + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Reset, hand-off and one full run; returns the hand-off cycle
   task automatic start_run(output int c0);
      rec_clr = 1'b1;
      pwr_stable = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cke == 1'b0 && init_done == 1'b0, "R12", "reset cke/done", {cke, init_done}, 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "reset bus code", {cs_n, ras_n, cas_n, we_n}, 7);
      rst_n = 1'b1;
      rec_clr = 1'b0;
      repeat (5) @(negedge clk);
      chk(cke == 1'b0, "R1", "cke before pwr_stable", cke, 0);
      c0 = cyc;
      pwr_stable = 1'b1;
   endtask

   task automatic full_run();
      int c0, cke_rise, done_at;
      start_run(c0);
      cke_rise = -1;
      done_at = -1;
      while (done_at < 0 && cyc < WD_LIMIT) begin
         @(negedge clk);
         if (cke && cke_rise < 0) cke_rise = cyc;
         if (init_done) done_at = cyc;
      end
      chk(cke_rise - c0 == O_CKE, "R1", "cke rise offset", cke_rise - c0, O_CKE);
      chk(bad_codes == 0, "R2", "illegal code cycles", bad_codes, 0);
      chk(n_rec == 8, "R3", "command count", n_rec, 8);
      for (int i = 0; i < 8 && i < n_rec; i++) begin
         logic [34:0] e;
         string otag;
         e = EXP_SEQ[i];
         chk(rec_cmd[i] == e[18:15], "R3", $sformatf("cmd %0d code", i), rec_cmd[i], e[18:15]);
         chk(rec_ba[i] == e[14:13], (e[18:15] == 4'b0010) ? "R4" : "R5",
             $sformatf("cmd %0d bank", i), rec_ba[i], e[14:13]);
         chk(rec_addr[i] == e[12:0], (e[18:15] == 4'b0010) ? "R4" : "R5",
             $sformatf("cmd %0d addr", i), rec_addr[i], e[12:0]);
         if (i == 0) otag = "R1";
         else if (i == 7) otag = "R9";
         else if (rec_cmd[i-1] == 4'b0000) otag = "R6";
         else if (rec_cmd[i-1] == 4'b0010) otag = "R7";
         else otag = "R8";
         chk(rec_cyc[i] - c0 == int'(e[34:19]), otag, $sformatf("cmd %0d offset", i),
             rec_cyc[i] - c0, int'(e[34:19]));
      end
      chk(done_at - c0 == O_DONE, "R10", "init_done offset", done_at - c0, O_DONE);
   endtask

   initial begin
      full_run();

      // R11: pass-through after completion, two patterns
      @(negedge clk);
      ctl_cke = 1'b1; ctl_cs_n = 1'b0; ctl_ras_n = 1'b1; ctl_cas_n = 1'b0; ctl_we_n = 1'b1;
      ctl_ba = 2'b10; ctl_addr = 13'h1A5;
      #1;
      chk({cke, cs_n, ras_n, cas_n, we_n, ba, addr} == {5'b10101, 2'b10, 13'h1A5}, "R11",
          "pass-through A", {cke, cs_n, ras_n, cas_n, we_n, ba, addr}, {5'b10101, 2'b10, 13'h1A5});
      @(negedge clk);
      ctl_cke = 1'b0; ctl_cs_n = 1'b1; ctl_ras_n = 1'b0; ctl_cas_n = 1'b1; ctl_we_n = 1'b0;
      ctl_ba = 2'b01; ctl_addr = 13'h0F0;
      #1;
      chk({cke, cs_n, ras_n, cas_n, we_n, ba, addr} == {5'b01010, 2'b01, 13'h0F0}, "R11",
          "pass-through B", {cke, cs_n, ras_n, cas_n, we_n, ba, addr}, {5'b01010, 2'b01, 13'h0F0});

      // R10: done holds while pwr_stable toggles
      begin
         int drops = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            pwr_stable = ~pwr_stable;
            if (!init_done) drops++;
         end
         chk(drops == 0, "R10", "done drop cycles", drops, 0);
      end

      // R12: abort mid-sequence, then full rerun
      begin
         int c0;
         start_run(c0);
         repeat (O_E + 2) @(negedge clk);
         rst_n = 1'b0;
         #1;
         chk(cke == 1'b0 && init_done == 1'b0, "R12", "mid-run reset cke/done", {cke, init_done}, 0);
         chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R12", "mid-run reset bus", {cs_n, ras_n, cas_n, we_n}, 7);
      end
      full_run();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule